// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

This block is a small synchronous counter that can be preset from a parallel input and then stepped upward or downward by one on each rising clock edge. A parameter picks its modulus: the full binary range of the counter width, or a decade range of 0 to 9. Two active-low enables must both be asserted for a count step to happen. The second of them, the carry enable, also gates an active-low terminal flag. This lets several counters be chained into a wider synchronous counter, with each stage's flag feeding the carry enable of the next stage.

Parallel load overrides every other control. There is no reset of any kind. The count holds an arbitrary value until the first load. In decade mode, any of the six codes above nine that a load or power-up can leave in the register always drops back into the 0..9 cycle within two count steps. The terminal flag is decoded combinationally from the present count, the carry enable and the direction input.

Top module: `updn_counter`

## Requirements
- R1: When `load_n` is 0 at a rising clock edge, `count` takes the value of `preset` at that edge, whatever the enables and `up` are.
- R2: When `load_n` is 1 and either `cnt_en_p_n` or `cnt_en_t_n` is 1 at a rising edge, `count` keeps its value.
- R3: When `load_n` is 1 and both enables are 0, `up` = 1 adds one to a legal count.
- R4: Under the same enable conditions, `up` = 0 subtracts one from a nonzero legal count.
- R5: In binary mode (`DECADE` = 0, 4 bits), counting up from 15 gives 0 and counting down from 0 gives 15.
- R6: In decade mode (`DECADE` = 1), counting up from 9 gives 0 and counting down from 0 gives 9.
- R7: While `cnt_en_t_n` is 1, `tc_n` is 1.
- R8: While `cnt_en_t_n` is 0, `tc_n` is 0 exactly when the count is 0 with `up` = 0, or the count is the top legal value (15 binary, 9 decade) with `up` = 1.
- R9: `tc_n` does not depend on `cnt_en_p_n`.
- R10: In decade mode, with `cnt_en_t_n` = 0 and `up` = 1, the codes 11, 13 and 15 also drive `tc_n` to 0. Codes 10, 12 and 14 do not.
- R11: In decade mode, a count of 10..15 moves as follows. Counting up, 10, 12 and 14 go to the next odd code, and 11, 13 and 15 go to 0. Counting down, any of them goes to 9. The count is therefore back in 0..9 within two count steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state changes |
| load_n | input | 1 | Active-low parallel load; highest priority |
| cnt_en_p_n | input | 1 | Active-low count enable that does not affect the flag |
| cnt_en_t_n | input | 1 | Active-low count enable that also gates the terminal flag |
| up | input | 1 | Direction select: 1 increments, 0 decrements |
| preset | input | CNT_W | Value stored on a load |
| count | output | CNT_W | Present counter value |
| tc_n | output | 1 | Active-low terminal-count flag for cascading |

## Verification
The only state is the count register, so a wrong next value shows on `count` at the very next rising edge. It then feeds through the combinational decode to `tc_n` in the same cycle. A wrong decade recovery step shows on `count` one or two edges after an illegal code is loaded. A terminal decode that depends on the wrong inputs shows on `tc_n` as soon as the carry enable, direction or plain enable changes, with no clock needed. The reference model steps both counter variants on every edge and compares both outputs once per cycle. It covers every illegal preset in both directions.

// File: rtl/updn_pkg.sv
package updn_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_INC  = 2'd2,
      OP_DEC  = 2'd3
   } cnt_op_e;

   localparam int unsigned DEC_MAX = 9;

endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
   import updn_pkg::*;
(
   input  logic    load_n,
   input  logic    cnt_en_p_n,
   input  logic    cnt_en_t_n,
   input  logic    up,
   output cnt_op_e op
);

   always_comb begin
      if (!load_n)
         op = OP_LOAD;
      else if (!cnt_en_p_n && !cnt_en_t_n)
         op = up ? OP_INC : OP_DEC;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/updn_next.sv
module updn_next #(
   parameter int unsigned CNT_W  = 4,
   parameter bit          DECADE = 1'b0
) (
   input  logic [CNT_W-1:0] q,
   input  logic             up,
   output logic [CNT_W-1:0] q_step
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (DECADE) begin : g_dec
         localparam logic [CNT_W-1:0] TOP = CNT_W'(updn_pkg::DEC_MAX);
         always_comb begin
            if (q > TOP) begin
               if (up)
                  q_step = q[0] ? '0 : q + ONE;
               else
                  q_step = TOP;
            end else if (up) begin
               q_step = (q == TOP) ? '0 : q + ONE;
            end else begin
               q_step = (q == '0) ? TOP : q - ONE;
            end
         end
      end else begin : g_bin
         always_comb begin
            q_step = up ? q + ONE : q - ONE;
         end
      end
   endgenerate

endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
   parameter int unsigned CNT_W  = 4,
   parameter bit          DECADE = 1'b0
) (
   input  logic [CNT_W-1:0] q,
   input  logic             cnt_en_t_n,
   input  logic             up,
   output logic             tc_n
);

   logic hit_up;
   logic hit_dn;

   generate
      if (DECADE) begin : g_dec
         // 9, 11, 13 and 15 all have the top and bottom bits set
         assign hit_up = q[3] & q[0];
      end else begin : g_bin
         assign hit_up = &q;
      end
   endgenerate

   assign hit_dn = (q == '0);
   assign tc_n   = ~(~cnt_en_t_n & (up ? hit_up : hit_dn));

endmodule

// File: rtl/updn_counter.sv
module updn_counter
   import updn_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter bit          DECADE = 1'b0
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             cnt_en_p_n,
   input  logic             cnt_en_t_n,
   input  logic             up,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output logic             tc_n
);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("updn_counter: CNT_W must be at least 2");
      end
      if (DECADE && CNT_W != 4) begin : g_bad_dec
         $error("updn_counter: decade mode needs CNT_W of 4");
      end
   endgenerate

   cnt_op_e          op;
   logic [CNT_W-1:0] q;
   logic [CNT_W-1:0] q_step;

   updn_ctrl u_ctrl (
      .load_n     (load_n),
      .cnt_en_p_n (cnt_en_p_n),
      .cnt_en_t_n (cnt_en_t_n),
      .up         (up),
      .op         (op)
   );

   updn_next #(.CNT_W(CNT_W), .DECADE(DECADE)) u_next (
      .q      (q),
      .up     (up),
      .q_step (q_step)
   );

   updn_tc #(.CNT_W(CNT_W), .DECADE(DECADE)) u_tc (
      .q          (q),
      .cnt_en_t_n (cnt_en_t_n),
      .up         (up),
      .tc_n       (tc_n)
   );

   always_ff @(posedge clk) begin
      case (op)
         OP_LOAD: q <= preset;
         OP_INC,
         OP_DEC:  q <= q_step;
         default: q <= q;
      endcase
   end

   assign count = q;

endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
   parameter int unsigned CNT_W  = 4,
   parameter bit          DECADE = 1'b0
) (
   input logic             clk,
   input logic             load_n,
   input logic             cnt_en_p_n,
   input logic             cnt_en_t_n,
   input logic             up,
   input logic [CNT_W-1:0] preset,
   input logic [CNT_W-1:0] count,
   input logic             tc_n
);

   localparam logic [CNT_W-1:0] TOP = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // No reset exists: the checks start once a load has defined the state
   logic primed = 1'b0;
   always_ff @(posedge clk) if (!load_n) primed <= 1'b1;

   logic stepping;
   assign stepping = load_n && !cnt_en_p_n && !cnt_en_t_n;

   p_load_r1: assert property (@(posedge clk) !load_n |=> count == $past(preset));

   p_hold_r2: assert property (@(posedge clk) disable iff (!primed)
      (load_n && (cnt_en_p_n || cnt_en_t_n)) |=> $stable(count));

   p_inc_r3: assert property (@(posedge clk) disable iff (!primed)
      (stepping && up && count < TOP) |=> count == $past(count) + ONE);

   p_dec_r4: assert property (@(posedge clk) disable iff (!primed)
      (stepping && !up && count != '0 && count <= TOP) |=> count == $past(count) - ONE);

   p_wrap_up_r5_r6: assert property (@(posedge clk) disable iff (!primed)
      (stepping && up && count == TOP) |=> count == '0);

   p_wrap_dn_r5_r6: assert property (@(posedge clk) disable iff (!primed)
      (stepping && !up && count == '0) |=> count == TOP);

   p_tc_idle_r7: assert property (@(posedge clk) disable iff (!primed)
      cnt_en_t_n |-> tc_n);

   p_tc_top_r8: assert property (@(posedge clk) disable iff (!primed)
      (!cnt_en_t_n && up && count == TOP) |-> !tc_n);

   p_tc_zero_r8: assert property (@(posedge clk) disable iff (!primed)
      (!cnt_en_t_n && !up && count == '0) |-> !tc_n);

   generate
      if (DECADE) begin : g_dec
         p_tc_odd_illegal_r10: assert property (@(posedge clk) disable iff (!primed)
            (!cnt_en_t_n && up && count > TOP && count[0]) |-> !tc_n);

         p_rec_dn_r11: assert property (@(posedge clk) disable iff (!primed)
            (stepping && !up && count > TOP) |=> count == TOP);

         p_rec_up_r11: assert property (@(posedge clk) disable iff (!primed)
            (stepping && up && count > TOP) |=> (count == '0 || (count > TOP && count[0])));
      end
   endgenerate

endmodule

bind updn_counter updn_counter_chk #(.CNT_W(CNT_W), .DECADE(DECADE)) u_chk (
   .clk        (clk),
   .load_n     (load_n),
   .cnt_en_p_n (cnt_en_p_n),
   .cnt_en_t_n (cnt_en_t_n),
   .up         (up),
   .preset     (preset),
   .count      (count),
   .tc_n       (tc_n)
);

// File: tb/test_updn_counter.sv
`timescale 1ns/1ps
module test_updn_counter;

   logic       clk = 1'b0;
   logic       load_n = 1'b1;
   logic       cep_n = 1'b1;
   logic       cet_n = 1'b1;
   logic       up = 1'b1;
   logic [3:0] preset = 4'd0;
   logic [3:0] cnt_b, cnt_d;
   logic       tc_b, tc_d;

   int checks = 0;
   int errors = 0;
   int mb = 0;
   int md = 0;
   bit known = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   updn_counter i_updn_counter (
      .clk(clk), .load_n(load_n), .cnt_en_p_n(cep_n), .cnt_en_t_n(cet_n),
      .up(up), .preset(preset), .count(cnt_b), .tc_n(tc_b));

   updn_counter #(.DECADE(1'b1)) i_updn_counter_dec (
      .clk(clk), .load_n(load_n), .cnt_en_p_n(cep_n), .cnt_en_t_n(cet_n),
      .up(up), .preset(preset), .count(cnt_d), .tc_n(tc_d));

   function automatic int model_next(int q, bit dec, bit u);
      int top = dec ? 9 : 15;
      if (q > top) return u ? ((q % 2 == 1) ? 0 : q + 1) : 9;
      if (u) return (q == top) ? 0 : q + 1;
      return (q == 0) ? top : q - 1;
   endfunction

   function automatic int model_tc(int q, bit dec, bit t_n, bit u);
      if (t_n) return 1;
      if (!u) return (q == 0) ? 0 : 1;
      if (dec) return (q == 9 || q == 11 || q == 13 || q == 15) ? 0 : 1;
      return (q == 15) ? 0 : 1;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      string ttag;
      ttag = cet_n ? "R7" : tag;
      chk(tag,  "bin count", int'(cnt_b), mb);
      chk(tag,  "dec count", int'(cnt_d), md);
      chk(ttag, "bin tc_n",  int'(tc_b), model_tc(mb, 1'b0, cet_n, up));
      chk(ttag, "dec tc_n",  int'(tc_d), model_tc(md, 1'b1, cet_n, up));
   endtask

   // Inputs change just after a falling edge, results are sampled on the next falling edge
   task automatic step(bit l, bit p, bit t, bit u, int v, string tag);
      load_n = l; cep_n = p; cet_n = t; up = u; preset = 4'(v);
      @(posedge clk);
      if (!l) begin
         mb = v; md = v; known = 1'b1;
      end else if (!p && !t) begin
         mb = model_next(mb, 1'b0, u);
         md = model_next(md, 1'b1, u);
      end
      @(negedge clk);
      if (known) compare(tag);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      @(negedge clk);
      // R1: first load defines the state; enables asserted to show priority
      step(1'b0, 1'b1, 1'b1, 1'b1, 0, "R1");
      step(1'b0, 1'b0, 1'b0, 1'b1, 5, "R1");
      step(1'b0, 1'b0, 1'b0, 1'b0, 7, "R1");
      // R2: each disabled combination holds
      step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R2");
      step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R2");
      step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R2");
      // R3, R5, R6, R8: up through both wraps
      step(1'b0, 1'b1, 1'b1, 1'b1, 0, "R1");
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 0, (i % 10 == 9 || i % 16 == 15) ? "R5" : "R3");
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 0, "R6");
      // R4, R5, R6, R8: down through both wraps
      step(1'b0, 1'b1, 1'b1, 1'b0, 3, "R1");
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R4");
      step(1'b0, 1'b1, 1'b1, 1'b0, 0, "R1");
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R6");
      // R8 and R9: terminal states with CEP held high
      step(1'b0, 1'b1, 1'b1, 1'b1, 9, "R1");
      step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R8");
      step(1'b0, 1'b1, 1'b1, 1'b1, 15, "R1");
      step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R9");
      // R9: toggle CEP between edges and watch the flag stay put
      #2; chk("R9", "bin tc_n cep high", int'(tc_b), 0);
      chk("R9", "dec tc_n cep high", int'(tc_d), 0);
      cep_n = 1'b0; #2;
      chk("R9", "bin tc_n cep low", int'(tc_b), 0);
      chk("R9", "dec tc_n cep low", int'(tc_d), 0);
      cep_n = 1'b1; #2;
      @(negedge clk);
      // R10: every illegal decade code with up and CET low
      for (int v = 10; v < 16; v++) begin
         step(1'b0, 1'b1, 1'b1, 1'b1, v, "R1");
         step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R10");
         chk("R10", "dec tc_n illegal", int'(tc_d), (v % 2 == 1) ? 0 : 1);
      end
      // R11: recovery from every illegal code in both directions
      for (int v = 10; v < 16; v++) begin
         for (int d = 0; d < 2; d++) begin
            step(1'b0, 1'b1, 1'b1, 1'(d), v, "R1");
            step(1'b1, 1'b0, 1'b0, 1'(d), 0, "R11");
            step(1'b1, 1'b0, 1'b0, 1'(d), 0, "R11");
            chk("R11", "dec legal after two counts", (cnt_d <= 4'd9) ? 1 : 0, 1);
         end
      end
      // Mixed random traffic against the model
      for (int i = 0; i < 400; i++)
         step(($urandom % 8) != 0, $urandom % 4 == 0, $urandom % 4 == 0,
              1'($urandom), int'($urandom % 16), "R3");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual running expected finished");
         summary();
         $finish;
      end
   end

endmodule